// File: doc/BRIEF.md
# Control Register Bus Interface

This block sits between an 8-bit asynchronous control bus and the timing and readout logic of a multi-channel time digitizer. The bus has four parts: an active-low chip-select strobe, a read select, a 2-bit register address, and active-low data lines. Through the bus, software reaches four registers:

- a control word that drives the readout and test logic;
- two windows onto the 7-bit read and write pointer counters (a write loads the counter, a read returns its live count);
- a test register that holds a 6-bit test pattern and a serial-in bit, and returns a serial-out bit taken from the encoder it shifts into.

Chip-select is brought into the clock domain through a synchronizer. Each access commits when chip-select is released. A write commit updates storage or issues a one-cycle load pulse to the pointer counter. When shifting is enabled, any completed access to the test register also issues a one-cycle shift pulse to the selected encode register. Read data is returned combinationally from the address lines. The data lines are inverted and are enabled only while a read is selected.

Top module: `csr_bus_if`

## Requirements
- R1: After synchronous reset, every control output, the test pattern, the serial-in bit and the load and shift pulses are 0. Register 0 reads 0x00 and register 3 reads back only the serial-out input, in bit 7.
- R2: A write takes effect on the third rising clock edge after chip-select goes high, which is the first edge at which the two-stage synchronized strobe is seen released. No pulse appears before that edge.
- R3: The register 0 fields map to outputs as follows:
  - bit 7: memory-test enable;
  - bit 6: read-pointer sync inhibit;
  - bit 5: shift enable;
  - bit 4: read-pointer auto-increment;
  - bits 3:2: test channel;
  - bit 0: falling-edge test select.
  Bit 1 always reads 0.
- R4: A write to register 1 gives a one-cycle read-pointer load pulse, with data bits 6:0 on the load value. Bit 7 is ignored. A read of register 1 returns the live read-pointer count, with bit 7 as 0.
- R5: A write to register 2 gives a one-cycle write-pointer load pulse, with data bits 6:0 on the load value. Bit 7 is ignored. A read of register 2 returns the live write-pointer count, with bit 7 as 0.
- R6: Register 3 holds the test pattern in bits 5:0 and the serial-in bit in bit 6, both read/write. Bit 7 reads the serial-out input, and a write to bit 7 has no effect.
- R7: While shift enable is 1, each completed register 3 access, read or write, gives exactly one shift pulse. The serial-in output already holds any value written by that access. Accesses to other registers, or any access while shift enable is 0, give no shift pulse.
- R8: The data lines carry the inverted register contents. The output enable is high only while chip-select is low and read is selected. At all other times the data output is all ones.
- R9: A read access alters no register and gives no load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip-select strobe, active low |
| bus_rd | input | 1 | 1 = read access, 0 = write access |
| bus_addr | input | 2 | Register address |
| bus_din_n | input | 8 | Write data from the bus, active low |
| bus_dout_n | output | 8 | Read data to the bus, active low |
| bus_oe | output | 1 | Enables the bus data drivers |
| rd_ptr_cnt | input | 7 | Live read-pointer count |
| wr_ptr_cnt | input | 7 | Live write-pointer count |
| rd_ptr_load | output | 1 | One-cycle read-pointer load pulse |
| wr_ptr_load | output | 1 | One-cycle write-pointer load pulse |
| ptr_load_val | output | 7 | Value to load into the pointer counter |
| mem_test_en | output | 1 | Memory test path select |
| rp_sync_inhibit | output | 1 | Blocks read-pointer stepping with the write cycle |
| shift_en | output | 1 | Serial shift enable |
| rp_auto_inc | output | 1 | Read-pointer step after an asynchronous readout |
| test_chan | output | 2 | Test channel select |
| test_fall_sel | output | 1 | 1 = falling-edge test data, 0 = rising-edge test data |
| test_data | output | 6 | Test pattern for the memory input |
| serial_in_bit | output | 1 | Bit to shift into the encode register |
| serial_out_bit | input | 1 | Bit shifted out of the encode register |
| shift_pulse | output | 1 | One-cycle shift strobe |

## Verification
A stuck synchronizer stage or a wrong edge detector shows at the ports as a load or shift pulse that arrives one cycle early, one cycle late, or never. The bench looks for this in the cycles after release. A register field decoded into the wrong bit shows on the very next control-output sample, or on the next readback of that register. A read path that decodes the wrong register, or skips the inversion, shows on the data lines while the read is still held. A shift gate that is wrong shows as a pulse after a register 1 access or while shifting is disabled.

// File: rtl/csr_bus_pkg.sv
package csr_bus_pkg;

    localparam int CSR_DW = 8;
    localparam int PTR_W  = 7;
    localparam int TD_W   = 6;
    localparam int ADDR_W = 2;
    localparam int PAD_W  = CSR_DW - PTR_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_RPTR = 2'd1,
        REG_WPTR = 2'd2,
        REG_TEST = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       mem_test;
        logic       rp_sync_inh;
        logic       shift_en;
        logic       rp_auto_inc;
        logic [1:0] test_chan;
        logic       rsvd;
        logic       test_fall;
    } ctrl_reg_t;

    typedef struct packed {
        logic            sin;
        logic [TD_W-1:0] tdata;
    } test_reg_t;

    typedef struct packed {
        logic              rd;
        reg_sel_e          sel;
        logic [CSR_DW-1:0] data;
    } bus_acc_t;

    function automatic ctrl_reg_t ctrl_from_word(input logic [CSR_DW-1:0] w);
        ctrl_reg_t c;
        c      = ctrl_reg_t'(w);
        c.rsvd = 1'b0;
        return c;
    endfunction

    function automatic logic [CSR_DW-1:0] ptr_to_word(input logic [PTR_W-1:0] p);
        return {{PAD_W{1'b0}}, p};
    endfunction

endpackage

// File: rtl/csr_bus_sync.sv
module csr_bus_sync
    import csr_bus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_cs_n,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CSR_DW-1:0]   bus_din_n,
    output logic                acc_end,
    output bus_acc_t            acc
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              rel_q;
    logic              cs_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            rel_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], bus_cs_n};
            rel_q  <= sync_q[LAST];
        end
    end

    assign cs_active = ~sync_q[LAST];
    assign acc_end   = sync_q[LAST] & ~rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (cs_active) begin
            acc.rd   <= bus_rd;
            acc.sel  <= reg_sel_e'(bus_addr);
            acc.data <= ~bus_din_n;
        end
    end

endmodule

// File: rtl/csr_bus_regfile.sv
module csr_bus_regfile
    import csr_bus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_end,
    input  bus_acc_t         acc,
    output ctrl_reg_t        ctrl_q,
    output test_reg_t        test_q,
    output logic             rd_ld,
    output logic             wr_ld,
    output logic [PTR_W-1:0] ld_val,
    output logic             shift_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            test_q  <= '0;
            rd_ld   <= 1'b0;
            wr_ld   <= 1'b0;
            ld_val  <= '0;
            shift_q <= 1'b0;
        end else begin
            rd_ld   <= 1'b0;
            wr_ld   <= 1'b0;
            shift_q <= 1'b0;
            if (acc_end) begin
                if (!acc.rd) begin
                    case (acc.sel)
                        REG_CTRL: ctrl_q <= ctrl_from_word(acc.data);
                        REG_RPTR: begin
                            rd_ld  <= 1'b1;
                            ld_val <= acc.data[PTR_W-1:0];
                        end
                        REG_WPTR: begin
                            wr_ld  <= 1'b1;
                            ld_val <= acc.data[PTR_W-1:0];
                        end
                        default:  test_q <= test_reg_t'(acc.data[TD_W:0]);
                    endcase
                end
                if (acc.sel == REG_TEST && ctrl_q.shift_en)
                    shift_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/csr_bus_rdmux.sv
module csr_bus_rdmux
    import csr_bus_pkg::*;
(
    input  logic [ADDR_W-1:0] sel,
    input  ctrl_reg_t         ctrl_q,
    input  test_reg_t         test_q,
    input  logic              sout,
    input  logic [PTR_W-1:0]  rd_cnt,
    input  logic [PTR_W-1:0]  wr_cnt,
    output logic [CSR_DW-1:0] word
);

    always_comb begin
        case (reg_sel_e'(sel))
            REG_CTRL: word = ctrl_q;
            REG_RPTR: word = ptr_to_word(rd_cnt);
            REG_WPTR: word = ptr_to_word(wr_cnt);
            default:  word = {sout, test_q};
        endcase
    end

endmodule

// File: rtl/csr_bus_if.sv
module csr_bus_if
    import csr_bus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CSR_DW-1:0] bus_din_n,
    output logic [CSR_DW-1:0] bus_dout_n,
    output logic              bus_oe,
    input  logic [PTR_W-1:0]  rd_ptr_cnt,
    input  logic [PTR_W-1:0]  wr_ptr_cnt,
    output logic              rd_ptr_load,
    output logic              wr_ptr_load,
    output logic [PTR_W-1:0]  ptr_load_val,
    output logic              mem_test_en,
    output logic              rp_sync_inhibit,
    output logic              shift_en,
    output logic              rp_auto_inc,
    output logic [1:0]        test_chan,
    output logic              test_fall_sel,
    output logic [TD_W-1:0]   test_data,
    output logic              serial_in_bit,
    input  logic              serial_out_bit,
    output logic              shift_pulse
);

    logic              acc_end;
    bus_acc_t          acc;
    ctrl_reg_t         ctrl_q;
    test_reg_t         test_q;
    logic [CSR_DW-1:0] rd_word;

    csr_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst       (rst),
        .bus_cs_n  (bus_cs_n),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_din_n (bus_din_n),
        .acc_end   (acc_end),
        .acc       (acc)
    );

    csr_bus_regfile regs_i (
        .clk     (clk),
        .rst     (rst),
        .acc_end (acc_end),
        .acc     (acc),
        .ctrl_q  (ctrl_q),
        .test_q  (test_q),
        .rd_ld   (rd_ptr_load),
        .wr_ld   (wr_ptr_load),
        .ld_val  (ptr_load_val),
        .shift_q (shift_pulse)
    );

    csr_bus_rdmux mux_i (
        .sel    (bus_addr),
        .ctrl_q (ctrl_q),
        .test_q (test_q),
        .sout   (serial_out_bit),
        .rd_cnt (rd_ptr_cnt),
        .wr_cnt (wr_ptr_cnt),
        .word   (rd_word)
    );

    assign bus_oe          = ~bus_cs_n & bus_rd;
    assign bus_dout_n      = bus_oe ? ~rd_word : '1;
    assign mem_test_en     = ctrl_q.mem_test;
    assign rp_sync_inhibit = ctrl_q.rp_sync_inh;
    assign shift_en        = ctrl_q.shift_en;
    assign rp_auto_inc     = ctrl_q.rp_auto_inc;
    assign test_chan       = ctrl_q.test_chan;
    assign test_fall_sel   = ctrl_q.test_fall;
    assign test_data       = test_q.tdata;
    assign serial_in_bit   = test_q.sin;

endmodule

// File: rtl/csr_bus_if_chk.sv
module csr_bus_if_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_cs_n,
    input logic       bus_oe,
    input logic [7:0] bus_dout_n,
    input logic       rd_ptr_load,
    input logic       wr_ptr_load,
    input logic       shift_pulse,
    input logic       shift_en
);

    // R8: a deselected bus is never driven
    assert_bus_released_R8: assert property (@(posedge clk) disable iff (rst)
        bus_cs_n |-> (!bus_oe && bus_dout_n == 8'hFF));

    // R4: the read-pointer load lasts one cycle
    assert_rd_load_single_R4: assert property (@(posedge clk) disable iff (rst)
        rd_ptr_load |=> !rd_ptr_load);

    // R5: the write-pointer load lasts one cycle
    assert_wr_load_single_R5: assert property (@(posedge clk) disable iff (rst)
        wr_ptr_load |=> !wr_ptr_load);

    // R7: a shift strobe needs shift enable and is a single cycle
    assert_shift_gated_R7: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |-> shift_en);

    assert_shift_single_R7: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> !shift_pulse);

    // R2: commit events appear only after chip-select has been high for a while
    assert_commit_after_release_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr_load || wr_ptr_load || shift_pulse) |->
            (bus_cs_n && $past(bus_cs_n) && $past(bus_cs_n, 2)));

    // R9: a single access never loads both pointers
    assert_one_load_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_ptr_load, wr_ptr_load}));

endmodule

bind csr_bus_if csr_bus_if_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_cs_n    (bus_cs_n),
    .bus_oe      (bus_oe),
    .bus_dout_n  (bus_dout_n),
    .rd_ptr_load (rd_ptr_load),
    .wr_ptr_load (wr_ptr_load),
    .shift_pulse (shift_pulse),
    .shift_en    (shift_en)
);

// File: tb/csr_bus_if_tb.sv
`timescale 1ns/1ps
module csr_bus_if_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cs_n = 1'b1;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_din_n = 8'hFF;
    logic [7:0] bus_dout_n;
    logic       bus_oe;
    logic [6:0] rd_ptr_cnt = 7'h00;
    logic [6:0] wr_ptr_cnt = 7'h00;
    logic       rd_ptr_load, wr_ptr_load, shift_pulse;
    logic [6:0] ptr_load_val;
    logic       mem_test_en, rp_sync_inhibit, shift_en, rp_auto_inc, test_fall_sel;
    logic [1:0] test_chan;
    logic [5:0] test_data;
    logic       serial_in_bit;
    logic       serial_out_bit = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    csr_bus_if dut_i (
        .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_din_n(bus_din_n), .bus_dout_n(bus_dout_n),
        .bus_oe(bus_oe), .rd_ptr_cnt(rd_ptr_cnt), .wr_ptr_cnt(wr_ptr_cnt),
        .rd_ptr_load(rd_ptr_load), .wr_ptr_load(wr_ptr_load),
        .ptr_load_val(ptr_load_val), .mem_test_en(mem_test_en),
        .rp_sync_inhibit(rp_sync_inhibit), .shift_en(shift_en),
        .rp_auto_inc(rp_auto_inc), .test_chan(test_chan),
        .test_fall_sel(test_fall_sel), .test_data(test_data),
        .serial_in_bit(serial_in_bit), .serial_out_bit(serial_out_bit),
        .shift_pulse(shift_pulse)
    );

    // entry = {addr[1:0], write data[7:0], expected[7:0]}
    // addr 0/3: expected readback; addr 1/2: expected load value
    localparam int NVEC = 10;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 8'hFF, 8'hFD},
        {2'd0, 8'h02, 8'h00},
        {2'd0, 8'h95, 8'h95},
        {2'd3, 8'h7A, 8'h7A},
        {2'd3, 8'hC5, 8'h45},
        {2'd1, 8'hFF, 8'h7F},
        {2'd2, 8'h80, 8'h00},
        {2'd2, 8'h2B, 8'h2B},
        {2'd1, 8'h55, 8'h55},
        {2'd0, 8'h00, 8'h00}
    };

    logic [7:0] r_data;
    logic       r_oe, r_early, r_rld, r_wld, r_shp, r_sbit, r_late;
    logic [6:0] r_lval;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_access(input logic rd, input logic [1:0] a, input logic [7:0] wd);
        @(negedge clk);
        bus_addr  = a;
        bus_rd    = rd;
        bus_din_n = ~wd;
        bus_cs_n  = 1'b0;
        repeat (3) @(negedge clk);
        r_data   = ~bus_dout_n;
        r_oe     = bus_oe;
        bus_cs_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 r_early = rd_ptr_load | wr_ptr_load | shift_pulse;
        @(posedge clk);
        #1;
        r_rld  = rd_ptr_load;
        r_wld  = wr_ptr_load;
        r_shp  = shift_pulse;
        r_lval = ptr_load_val;
        r_sbit = serial_in_bit;
        @(posedge clk);
        #1 r_late = rd_ptr_load | wr_ptr_load | shift_pulse;
        @(negedge clk);
        bus_rd    = 1'b0;
        bus_din_n = 8'hFF;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 ctrl outputs", {mem_test_en, rp_sync_inhibit, shift_en, rp_auto_inc,
                                test_chan, test_fall_sel}, 0);
        chk("R1 pulses", {rd_ptr_load, wr_ptr_load, shift_pulse}, 0);
        chk("R1 test data", {serial_in_bit, test_data}, 0);
        chk("R8 idle bus", {bus_oe, bus_dout_n}, {1'b0, 8'hFF});
        bus_access(1'b1, 2'd0, 8'h00);
        chk("R1 reg0 read", r_data, 8'h00);
        chk("R8 read enables bus", r_oe, 1'b1);
        serial_out_bit = 1'b1;
        bus_access(1'b1, 2'd3, 8'h00);
        chk("R1 R6 reg3 read after reset", r_data, 8'h80);
        serial_out_bit = 1'b0;

        // table-driven write / readback
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] a;
            logic [7:0] wd, ex;
            {a, wd, ex} = VEC[i];
            bus_access(1'b0, a, wd);
            chk("R8 write leaves bus undriven", r_oe, 1'b0);
            chk("R2 no early commit", r_early, 1'b0);
            chk("R2 single-cycle commit", r_late, 1'b0);
            if (a == 2'd1 || a == 2'd2) begin
                chk(a == 2'd1 ? "R4 rd load pulse" : "R5 wr load pulse",
                    {r_rld, r_wld}, a == 2'd1 ? 2'b10 : 2'b01);
                chk(a == 2'd1 ? "R4 load value" : "R5 load value", r_lval, ex[6:0]);
            end else begin
                chk("R3 R6 no shift while disabled", r_shp, 1'b0);
                bus_access(1'b1, a, 8'h00);
                chk(a == 2'd0 ? "R3 reg0 readback" : "R6 reg3 readback", r_data, ex);
            end
        end

        // R3 field mapping
        bus_access(1'b0, 2'd0, 8'h95);
        chk("R3 fields 0x95", {mem_test_en, rp_sync_inhibit, shift_en, rp_auto_inc,
                               test_chan, test_fall_sel}, 7'b1001011);
        bus_access(1'b0, 2'd0, 8'h6A);
        chk("R3 fields 0x6A", {mem_test_en, rp_sync_inhibit, shift_en, rp_auto_inc,
                               test_chan, test_fall_sel}, 7'b0110100);

        // R7 shifting with enable set
        bus_access(1'b0, 2'd3, 8'h40);
        chk("R7 shift on reg3 write", {r_shp, r_sbit}, 2'b11);
        chk("R6 test data", test_data, 6'h00);
        serial_out_bit = 1'b1;
        bus_access(1'b1, 2'd3, 8'h00);
        chk("R7 shift on reg3 read", r_shp, 1'b1);
        chk("R6 reg3 read with sout", r_data, 8'hC0);
        bus_access(1'b0, 2'd1, 8'h11);
        chk("R7 no shift on reg1", r_shp, 1'b0);
        bus_access(1'b0, 2'd0, 8'h00);
        bus_access(1'b0, 2'd3, 8'h40);
        chk("R7 no shift when disabled", r_shp, 1'b0);

        // R9 reads are side-effect free and see live counts
        rd_ptr_cnt = 7'h5A;
        wr_ptr_cnt = 7'h33;
        bus_access(1'b1, 2'd1, 8'hFF);
        chk("R4 live rd count", r_data, 8'h5A);
        chk("R9 read no load", {r_rld, r_wld}, 2'b00);
        bus_access(1'b1, 2'd2, 8'hFF);
        chk("R5 live wr count", r_data, 8'h33);
        chk("R9 read no load wr", {r_rld, r_wld}, 2'b00);
        bus_access(1'b1, 2'd0, 8'hFF);
        chk("R9 reg0 unchanged", r_data, 8'h00);
        chk("R9 reg3 unchanged", {serial_in_bit, test_data}, 7'h40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule